// File: doc/BRIEF.md
# Prioritised Foreground Sprite Pixel Selector

This block works out which foreground sprite, if any, owns the pixel at one screen coordinate. A start pulse latches the coordinate and the global sprite-enable bit. A controller then walks the sprite attribute table from entry 0 to entry 127, one entry at a time. Each entry is a 32-bit attribute read as two 16-bit words. The block tests whether the sprite's 16x16 rectangle contains the coordinate. When it does, the block fetches the one or two tile words that hold the 3-bit pixel and extracts that pixel. Any non-zero pixel replaces the winner kept so far.

When the walk ends, a one-cycle done pulse is raised. A hit flag and a 6-bit colour index (palette index joined to the pixel value) are registered at that point and stay fixed until the next scan ends. The attribute and tile memories are outside the block and answer in the same cycle. The block drives the addresses and reads the returned words.

The controller states are: IDLE (waits for start), RD_HI (reads the upper attribute word), RD_LO (reads the lower word), CHECK (tests coverage), RD_PIX0 (reads the first tile word), RD_PIX1 (reads the following word when the pixel crosses a word boundary), MERGE (updates the winner), NEXT (steps the index or commits the result) and FINISH (raises done). The transitions are:
- IDLE to RD_HI on start with enable set, and IDLE to FINISH on start with enable clear.
- RD_HI to RD_LO, then RD_LO to CHECK.
- CHECK to RD_PIX0 when the sprite covers the coordinate, otherwise CHECK to NEXT.
- RD_PIX0 to RD_PIX1 on a word crossing, otherwise RD_PIX0 to MERGE.
- RD_PIX1 to MERGE, then MERGE to NEXT.
- NEXT to RD_HI while entries remain, and NEXT to FINISH after entry 127.
- FINISH to IDLE.

Top module: `spr_pick`

## Requirements
- R1: After reset, done_o, hit_o and color_o are all 0.
- R2: A start in IDLE begins a scan. done_o is high for exactly one cycle after entry 127 has been examined. hit_o and color_o change only in a cycle where done_o is high, and otherwise hold their value.
- R3: Entry i occupies attribute word 2i (bits 31..16) and word 2i+1 (bits 15..0). The fields are: bit 31 horizontal mirror, bit 30 vertical mirror, bits 29..21 stored X, bits 20..13 stored Y, bits 12..10 palette, bits 9..0 tile number.
- R4: A sprite covers (x, y) when 0 ≤ x − (X − 16) < 16 and 0 ≤ y − (Y − 16) < 16, computed signed. A sprite can therefore hang off the left or top edge.
- R5: Tile t occupies 48 words starting at tile address 48·t. Pixel n = row·16 + col uses bit-stream positions 3n..3n+2, counted from bit 15 of the first word downward, with its most significant bit first. A pixel may span two words.
- R6: A horizontal mirror reads column 15 − col. A vertical mirror reads row 15 − row.
- R7: A pixel value of 0 is transparent and leaves the current winner unchanged.
- R8: Where covering sprites give non-zero pixels, the entry with the highest index wins.
- R9: color_o is {palette, pixel} of the winner and hit_o is 1. With no winner, hit_o is 0 and color_o is 0.
- R10: With the enable bit clear at start, the scan still ends with a done pulse, and hit_o is 0 and color_o is 0 even if a sprite covers the point.
- R11: A start that arrives during a scan is ignored. The coordinate is latched at the accepted start, and no extra done pulse follows.
- R12: When no sprite covers the point, the result is hit_o = 0 and color_o = 0.

## Ports
| Port | Direction | Width | Description |
|-|-|-|-|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | begin a scan (accepted in IDLE only) |
| fetch_en_i | input | 1 | global sprite enable, sampled at start |
| pos_x_i | input | 9 | screen column to resolve |
| pos_y_i | input | 8 | screen row to resolve |
| attr_addr_o | output | 8 | attribute word address |
| attr_rdata_i | input | 16 | attribute word returned in the same cycle |
| tile_addr_o | output | 16 | tile word address |
| tile_rdata_i | input | 16 | tile word returned in the same cycle |
| done_o | output | 1 | one-cycle end-of-scan pulse |
| hit_o | output | 1 | a sprite pixel was found |
| color_o | output | 6 | palette and pixel of the winner |

## Verification
Two functions can land on the same point and the same cycle window:
- **Winner replacement against transparency.** Two sprites share a rectangle and the higher-index one is fully transparent. The bench checks that the lower sprite's colour survives. It then adds an opaque higher sprite and checks that it takes over.
- **Restart refusal against the running scan.** A second start, with a different coordinate, is pulsed in the middle of a scan. The bench requires exactly one done pulse, carrying the first coordinate's winner, and no further pulse for hundreds of cycles afterwards.

A scoreboard queue holds the expected result computed from the stored pixel map. Any extra or missing done pulse therefore shows up as a queue mismatch.

// File: rtl/spr_pick_pkg.sv
`timescale 1ns/1ps
package spr_pick_pkg;
    localparam int HPOS_W = 9;
    localparam int VPOS_W = 8;
    localparam int PAL_W  = 3;
    localparam int TILE_W = 10;
    localparam int BPP    = 3;
    localparam int WORD_W = 16;
    localparam int WSEL_W = $clog2(WORD_W);
    localparam int COL_W  = PAL_W + BPP;

    // Field order is the bit layout of the 32-bit attribute, MSB first
    typedef struct packed {
        logic              hflip;
        logic              vflip;
        logic [HPOS_W-1:0] hpos;
        logic [VPOS_W-1:0] vpos;
        logic [PAL_W-1:0]  pal;
        logic [TILE_W-1:0] tile;
    } spr_attr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_HI,
        ST_RD_LO,
        ST_CHECK,
        ST_RD_PIX0,
        ST_RD_PIX1,
        ST_MERGE,
        ST_NEXT,
        ST_FINISH
    } scan_state_e;
endpackage

// File: rtl/spr_geom.sv
`timescale 1ns/1ps
module spr_geom
    import spr_pick_pkg::*;
#(
    parameter int X_W      = 9,
    parameter int Y_W      = 8,
    parameter int SPR_DIM  = 16,
    parameter int POS_BIAS = 16,
    parameter int TADDR_W  = 16
) (
    input  logic [X_W-1:0]    cur_x_i,
    input  logic [Y_W-1:0]    cur_y_i,
    input  logic              hflip_i,
    input  logic              vflip_i,
    input  logic [HPOS_W-1:0] hpos_i,
    input  logic [VPOS_W-1:0] vpos_i,
    input  logic [TILE_W-1:0] tile_i,
    output logic              covered_o,
    output logic [TADDR_W-1:0] word_addr_o,
    output logic [WSEL_W-1:0] bit_sel_o,
    output logic              straddle_o
);
    localparam int DX_W       = X_W + 2;
    localparam int DY_W       = Y_W + 2;
    localparam int LOC_W      = $clog2(SPR_DIM);
    localparam int BOFF_W     = $clog2(SPR_DIM * SPR_DIM * BPP);
    localparam int TILE_WORDS = SPR_DIM * SPR_DIM * BPP / WORD_W;
    localparam int WOFS_W     = BOFF_W - WSEL_W;

    logic [DX_W-1:0]    dx;
    logic [DY_W-1:0]    dy;
    logic               in_x, in_y;
    logic [LOC_W-1:0]   col, row;
    logic [2*LOC_W-1:0] pix_n;
    logic [BOFF_W-1:0]  boff;
    logic [WOFS_W-1:0]  word_ofs;

    // offset of the point inside the sprite box, unbiased positions
    always_comb begin
        dx = DX_W'(cur_x_i) - DX_W'(hpos_i) + DX_W'(POS_BIAS);
        dy = DY_W'(cur_y_i) - DY_W'(vpos_i) + DY_W'(POS_BIAS);
        in_x = !dx[DX_W-1] && (dx < DX_W'(SPR_DIM));
        in_y = !dy[DY_W-1] && (dy < DY_W'(SPR_DIM));
        covered_o = in_x && in_y;
    end

    // mirror and locate the pixel in the packed bit stream
    always_comb begin
        col = hflip_i ? (LOC_W'(SPR_DIM - 1) - dx[LOC_W-1:0]) : dx[LOC_W-1:0];
        row = vflip_i ? (LOC_W'(SPR_DIM - 1) - dy[LOC_W-1:0]) : dy[LOC_W-1:0];
        pix_n = {row, col};
        boff = BOFF_W'(pix_n) * BOFF_W'(BPP);
        word_ofs = boff[BOFF_W-1:WSEL_W];
        bit_sel_o = boff[WSEL_W-1:0];
        word_addr_o = TADDR_W'(tile_i) * TADDR_W'(TILE_WORDS) + TADDR_W'(word_ofs);
        straddle_o = bit_sel_o > WSEL_W'(WORD_W - BPP);
    end

    always_comb begin
        AST_WORD_IN_TILE: assert (!covered_o || (int'(word_ofs) < TILE_WORDS)); // R5
    end
endmodule

// File: rtl/spr_pix_extract.sv
`timescale 1ns/1ps
module spr_pix_extract
    import spr_pick_pkg::*;
(
    input  logic [WORD_W-1:0] first_i,
    input  logic [WORD_W-1:0] second_i,
    input  logic [WSEL_W-1:0] bit_sel_i,
    output logic [BPP-1:0]    pix_o
);
    localparam int CAT_W = 2 * WORD_W;
    localparam int SH_W  = $clog2(CAT_W) + 1;

    logic [CAT_W-1:0] cat;
    logic [SH_W-1:0]  sh;

    // stream runs from bit 15 of the first word into the second word
    always_comb begin
        cat = {first_i, second_i};
        sh  = SH_W'(CAT_W - BPP) - SH_W'(bit_sel_i);
        for (int k = 0; k < BPP; k++) begin
            pix_o[k] = cat[sh + SH_W'(k)];
        end
    end
endmodule

// File: rtl/spr_scan_fsm.sv
`timescale 1ns/1ps
module spr_scan_fsm
    import spr_pick_pkg::*;
#(
    parameter int NUM_SPR = 128,
    parameter int X_W     = 9,
    parameter int Y_W     = 8,
    parameter int TADDR_W = 16,
    parameter int AADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               fetch_en_i,
    input  logic [X_W-1:0]     pos_x_i,
    input  logic [Y_W-1:0]     pos_y_i,
    input  logic [WORD_W-1:0]  attr_rdata_i,
    input  logic [WORD_W-1:0]  tile_rdata_i,
    input  logic               covered_i,
    input  logic [TADDR_W-1:0] word_addr_i,
    input  logic               straddle_i,
    input  logic [BPP-1:0]     pix_i,
    output logic [AADDR_W-1:0] attr_addr_o,
    output logic [TADDR_W-1:0] tile_addr_o,
    output logic [X_W-1:0]     cur_x_o,
    output logic [Y_W-1:0]     cur_y_o,
    output spr_attr_t          attr_o,
    output logic [WORD_W-1:0]  word0_o,
    output logic [WORD_W-1:0]  word1_o,
    output logic               done_o,
    output logic               hit_o,
    output logic [COL_W-1:0]   color_o
);
    localparam int IDX_W = $clog2(NUM_SPR);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SPR - 1);

    scan_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              en_q;
    logic [WORD_W-1:0] hi_q, lo_q;
    logic              cand_hit;
    logic [COL_W-1:0]  cand_col;
    logic              res_hit;
    logic [COL_W-1:0]  res_col;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = fetch_en_i ? ST_RD_HI : ST_FINISH;
            ST_RD_HI:   state_d = ST_RD_LO;
            ST_RD_LO:   state_d = ST_CHECK;
            ST_CHECK:   state_d = covered_i ? ST_RD_PIX0 : ST_NEXT;
            ST_RD_PIX0: state_d = straddle_i ? ST_RD_PIX1 : ST_MERGE;
            ST_RD_PIX1: state_d = ST_MERGE;
            ST_MERGE:   state_d = ST_NEXT;
            ST_NEXT:    state_d = (idx_q == LAST_IDX) ? ST_FINISH : ST_RD_HI;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            en_q     <= 1'b0;
            cur_x_o  <= '0;
            cur_y_o  <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            word0_o  <= '0;
            word1_o  <= '0;
            cand_hit <= 1'b0;
            cand_col <= '0;
            res_hit  <= 1'b0;
            res_col  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    cur_x_o  <= pos_x_i;
                    cur_y_o  <= pos_y_i;
                    en_q     <= fetch_en_i;
                    idx_q    <= '0;
                    cand_hit <= 1'b0;
                    cand_col <= '0;
                    if (!fetch_en_i) begin
                        res_hit <= 1'b0;
                        res_col <= '0;
                    end
                end
                ST_RD_HI:   hi_q    <= attr_rdata_i;
                ST_RD_LO:   lo_q    <= attr_rdata_i;
                ST_RD_PIX0: word0_o <= tile_rdata_i;
                ST_RD_PIX1: word1_o <= tile_rdata_i;
                ST_MERGE: if (pix_i != '0) begin
                    cand_hit <= 1'b1;
                    cand_col <= {attr_o.pal, pix_i};
                end
                ST_NEXT: begin
                    if (idx_q == LAST_IDX) begin
                        res_hit <= cand_hit;
                        res_col <= cand_col;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        attr_o      = spr_attr_t'({hi_q, lo_q});
        attr_addr_o = {idx_q, state_q == ST_RD_LO};
        tile_addr_o = word_addr_i + TADDR_W'(state_q == ST_RD_PIX1);
        done_o      = (state_q == ST_FINISH);
        hit_o       = res_hit;
        color_o     = res_col;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o != $past(hit_o) || color_o != $past(color_o)) |-> done_o); // R2
    AST_DISABLED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !en_q) |-> !hit_o); // R10
    AST_TRANSPARENT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MERGE && pix_i == '0) |=> $stable(cand_hit) && $stable(cand_col)); // R7
    AST_SECOND_WORD_ONLY_ON_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_PIX1) |-> ($past(state_q) == ST_RD_PIX0 && straddle_i)); // R5
    AST_INDEX_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_HI && $past(state_q) == ST_NEXT) |-> (idx_q == $past(idx_q) + 1'b1)); // R8
endmodule

// File: rtl/spr_pick.sv
`timescale 1ns/1ps
module spr_pick
    import spr_pick_pkg::*;
#(
    parameter int NUM_SPR  = 128,
    parameter int SPR_DIM  = 16,
    parameter int POS_BIAS = 16,
    parameter int X_W      = 9,
    parameter int Y_W      = 8,
    parameter int TADDR_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic                           fetch_en_i,
    input  logic [X_W-1:0]                 pos_x_i,
    input  logic [Y_W-1:0]                 pos_y_i,
    output logic [$clog2(NUM_SPR*2)-1:0]   attr_addr_o,
    input  logic [15:0]                    attr_rdata_i,
    output logic [TADDR_W-1:0]             tile_addr_o,
    input  logic [15:0]                    tile_rdata_i,
    output logic                           done_o,
    output logic                           hit_o,
    output logic [5:0]                     color_o
);
    localparam int AADDR_W = $clog2(NUM_SPR * 2);

    logic [X_W-1:0]     cur_x;
    logic [Y_W-1:0]     cur_y;
    spr_attr_t          attr;
    logic               covered;
    logic [TADDR_W-1:0] word_addr;
    logic [WSEL_W-1:0]  bit_sel;
    logic               straddle;
    logic [WORD_W-1:0]  word0, word1;
    logic [BPP-1:0]     pix;

    spr_scan_fsm #(
        .NUM_SPR (NUM_SPR),
        .X_W     (X_W),
        .Y_W     (Y_W),
        .TADDR_W (TADDR_W),
        .AADDR_W (AADDR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .fetch_en_i   (fetch_en_i),
        .pos_x_i      (pos_x_i),
        .pos_y_i      (pos_y_i),
        .attr_rdata_i (attr_rdata_i),
        .tile_rdata_i (tile_rdata_i),
        .covered_i    (covered),
        .word_addr_i  (word_addr),
        .straddle_i   (straddle),
        .pix_i        (pix),
        .attr_addr_o  (attr_addr_o),
        .tile_addr_o  (tile_addr_o),
        .cur_x_o      (cur_x),
        .cur_y_o      (cur_y),
        .attr_o       (attr),
        .word0_o      (word0),
        .word1_o      (word1),
        .done_o       (done_o),
        .hit_o        (hit_o),
        .color_o      (color_o)
    );

    spr_geom #(
        .X_W      (X_W),
        .Y_W      (Y_W),
        .SPR_DIM  (SPR_DIM),
        .POS_BIAS (POS_BIAS),
        .TADDR_W  (TADDR_W)
    ) u_geom (
        .cur_x_i     (cur_x),
        .cur_y_i     (cur_y),
        .hflip_i     (attr.hflip),
        .vflip_i     (attr.vflip),
        .hpos_i      (attr.hpos),
        .vpos_i      (attr.vpos),
        .tile_i      (attr.tile),
        .covered_o   (covered),
        .word_addr_o (word_addr),
        .bit_sel_o   (bit_sel),
        .straddle_o  (straddle)
    );

    spr_pix_extract u_extract (
        .first_i   (word0),
        .second_i  (word1),
        .bit_sel_i (bit_sel),
        .pix_o     (pix)
    );
endmodule

// File: tb/spr_pick_tb_top.sv
`timescale 1ns/1ps
module spr_pick_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fen = 1'b0;
    logic [8:0]  px = '0;
    logic [7:0]  py = '0;
    logic [7:0]  attr_addr;
    logic [15:0] attr_rdata;
    logic [15:0] tile_addr;
    logic [15:0] tile_rdata;
    logic        done;
    logic        hit;
    logic [5:0]  color;

    logic [15:0] attr_mem [0:255];
    logic [15:0] tile_mem [0:1023];
    logic [2:0]  pix_ref  [0:4095];

    int n_run = 0;
    int n_fail = 0;
    int n_done = 0;
    bit prev_done = 1'b0;
    bit finished = 1'b0;
    logic [6:0] exp_q [$];
    string      tag_q [$];
    logic [6:0] mon_e;
    string      mon_t;

    always #10 clk = ~clk; // 50 MHz

    assign attr_rdata = attr_mem[attr_addr];
    assign tile_rdata = tile_mem[tile_addr[9:0]];

    spr_pick dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .fetch_en_i   (fen),
        .pos_x_i      (px),
        .pos_y_i      (py),
        .attr_addr_o  (attr_addr),
        .attr_rdata_i (attr_rdata),
        .tile_addr_o  (tile_addr),
        .tile_rdata_i (tile_rdata),
        .done_o       (done),
        .hit_o        (hit),
        .color_o      (color)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        end
    endtask

    // R3 attribute packing
    task automatic set_sprite(int i, bit hf, bit vf, int hp, int vp, int pal, int t);
        logic [31:0] a;
        a = {hf, vf, 9'(hp), 8'(vp), 3'(pal), 10'(t)};
        attr_mem[2*i]   = a[31:16];
        attr_mem[2*i+1] = a[15:0];
    endtask

    // R5 stream packing, most significant pixel bit first
    task automatic pack_tiles();
        for (int w = 0; w < 1024; w++) tile_mem[w] = '0;
        for (int t = 0; t < 16; t++)
            for (int n = 0; n < 256; n++)
                for (int k = 0; k < 3; k++) begin
                    int s;
                    s = 3 * n + k;
                    tile_mem[t*48 + s/16][15 - (s % 16)] = pix_ref[t*256 + n][2-k];
                end
    endtask

    function automatic logic [6:0] ref_pixel(int x, int y, bit en);
        logic [6:0] r;
        r = '0;
        if (!en) return r;
        for (int i = 0; i < 128; i++) begin
            logic [31:0] a;
            int left, top, c, w;
            a = {attr_mem[2*i], attr_mem[2*i+1]};
            left = int'(a[29:21]) - 16;
            top  = int'(a[20:13]) - 16;
            if (x >= left && x < left + 16 && y >= top && y < top + 16) begin
                c = x - left;
                w = y - top;
                if (a[31]) c = 15 - c;
                if (a[30]) w = 15 - w;
                if (pix_ref[int'(a[9:0])*256 + w*16 + c] != 3'd0)
                    r = {1'b1, a[12:10], pix_ref[int'(a[9:0])*256 + w*16 + c]};
            end
        end
        return r;
    endfunction

    // monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                n_done++;
                if (prev_done) check(1'b0, "R2 done held longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 done without an accepted start", 1, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    check({hit, color} == mon_e, mon_t, int'({hit, color}), int'(mon_e));
                end
            end
            prev_done = done;
        end
    end

    task automatic run(int x, int y, bit en, string tag);
        int tgt;
        exp_q.push_back(ref_pixel(x, y, en));
        tag_q.push_back(tag);
        tgt = n_done + 1;
        @(negedge clk);
        px = 9'(x); py = 8'(y); fen = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (n_done >= tgt);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) attr_mem[i] = '0;
        for (int t = 0; t < 16; t++)
            for (int n = 0; n < 256; n++) begin
                if (t == 1)      pix_ref[t*256+n] = 3'd5;
                else if (t == 2) pix_ref[t*256+n] = 3'd0;
                else if (t == 0) pix_ref[t*256+n] = ((n % 3) == 0) ? 3'd0 : 3'(n % 8);
                else             pix_ref[t*256+n] = 3'(((t*3 + n*5 + n/7) % 7) + 1);
            end
        pack_tiles();

        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(hit == 1'b0, "R1 hit after reset", int'(hit), 0);
        check(color == 6'd0, "R1 color after reset", int'(color), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && hit == 1'b0 && color == 6'd0, "R1 outputs idle after release",
              int'({done, hit, color}), 0);

        run(50, 50, 1'b1, "R12 empty table gives no hit");

        set_sprite(5, 0, 0, 100, 50, 4, 3);
        run(90, 40, 1'b0, "R10 disabled hides covering sprite");
        run(90, 40, 1'b1, "R3 R9 single sprite colour");
        run(84, 34, 1'b1, "R4 top-left corner covered");
        run(99, 49, 1'b1, "R4 R5 bottom-right corner, last pixel");
        run(100, 40, 1'b1, "R4 one past right edge");
        run(83, 40, 1'b1, "R4 one before left edge");
        run(90, 33, 1'b1, "R4 one above top edge");
        run(90, 50, 1'b1, "R4 one below bottom edge");
        run(89, 34, 1'b1, "R5 pixel crossing words at bit 15");
        run(94, 34, 1'b1, "R5 pixel crossing words at bit 14");

        set_sprite(6, 0, 0, 5, 3, 1, 4);
        run(0, 0, 1'b1, "R4 sprite hanging off left and top");
        run(4, 2, 1'b1, "R4 last visible pixel of offscreen sprite");
        run(5, 2, 1'b1, "R4 beyond offscreen sprite");

        set_sprite(7, 1, 0, 216, 116, 3, 5);
        set_sprite(8, 0, 1, 256, 116, 2, 5);
        set_sprite(9, 1, 1, 296, 116, 6, 5);
        run(200, 100, 1'b1, "R6 horizontal mirror");
        run(203, 107, 1'b1, "R6 horizontal mirror inner");
        run(241, 102, 1'b1, "R6 vertical mirror");
        run(282, 113, 1'b1, "R6 both mirrors");

        set_sprite(10, 0, 0, 416, 216, 2, 1);
        set_sprite(20, 0, 0, 416, 216, 6, 2);
        run(405, 205, 1'b1, "R7 transparent higher sprite keeps lower");
        set_sprite(30, 0, 0, 416, 216, 5, 6);
        run(405, 205, 1'b1, "R8 higher index replaces lower");
        set_sprite(127, 0, 0, 410, 210, 7, 7);
        run(405, 205, 1'b1, "R8 last entry wins");
        run(412, 212, 1'b1, "R8 earlier sprite where last does not cover");
        set_sprite(0, 0, 0, 330, 150, 4, 0);
        run(320, 140, 1'b1, "R7 entry 0 with transparent pixel");
        run(321, 140, 1'b1, "R9 entry 0 opaque pixel");

        set_sprite(40, 0, 0, 511, 255, 0, 15);
        run(510, 254, 1'b1, "R3 maximum position and tile field");
        run(500, 240, 1'b1, "R3 R9 palette 0 colour");

        // R11: second start mid-scan with another coordinate
        begin
            int tgt;
            exp_q.push_back(ref_pixel(90, 40, 1'b1));
            tag_q.push_back("R11 result from first coordinate");
            tgt = n_done + 1;
            @(negedge clk);
            px = 9'd90; py = 8'd40; fen = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (20) @(negedge clk);
            px = 9'd405; py = 8'd205; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait (n_done >= tgt);
            repeat (900) @(negedge clk);
            check(n_done == tgt, "R11 no extra done after ignored start", n_done, tgt);
        end

        // R2: outputs hold while inputs move and no scan runs
        begin
            logic       h;
            logic [5:0] c;
            run(405, 205, 1'b1, "R2 result before hold check");
            h = hit; c = color;
            px = 9'd0; py = 8'd0; fen = 1'b0;
            repeat (30) @(negedge clk);
            check(hit == h && color == c, "R2 result held between scans",
                  int'({hit, color}), int'({h, c}));
        end

        summary();
        $finish;
    end
endmodule